// File: doc/BRIEF.md
# Head Positioning Command Sequencer

This block executes the head-positioning command group of a disk drive controller. A command byte selects one of three kinds of operation: restore, seek or single step. The block keeps a track register that shadows the head's believed cylinder, and a data register that holds a seek target. It issues step pulses with a direction level to the drive and waits a selectable step-rate delay after each pulse. A track-0 sensor input stops any outward movement early.

If the command asks for verification, the block waits for the head to settle once positioning ends. It then asks an external ID detector for sector IDs until one carries a track number equal to the track register, or until a time budget runs out. Completion clears busy and raises an interrupt. All delays come from a millisecond prescaler whose length is a parameter.

States: `ST_IDLE` (waits for a command) → `ST_PREP` (loads restore values, latches the step direction) → `ST_DECIDE` (compares the registers, updates the track, checks track 0) → `ST_PULSE` (step high) → `ST_RATE` (step-rate wait), which goes back to `ST_DECIDE` for a seek and to the finish for a step. The finish is `ST_SETTLE` (head settle) → `ST_IDWAIT` (ID search) when verify is set, and `ST_DONE` otherwise. `ST_DONE` raises the interrupt and returns to `ST_IDLE`.

Top module: `head_pos_seq`

## Requirements
- R1: After reset the outputs are: track and data registers 0, busy 0, irq 0, seek_err 0, step_out 0, and step_dir 1 (inward).
- R2: A command is accepted only when idle and cmd_byte[7] is 0, and busy rises on the next clock. While idle, a byte with bit 7 set is ignored. While busy, command strobes and track or data register writes are ignored.
- R3: When cmd_byte[6:5]=00 and bit 4 is 1 (seek), the block steps until track equals data. It steps inward (step_dir=1, track +1) when track < data, and outward (step_dir=0, track -1) otherwise. If the two are already equal it issues no pulse and leaves step_dir unchanged.
- R4: When cmd_byte[6:5]=00 and bit 4 is 0 (restore), the block loads 0xFF into the track register and 0 into the data register, then runs as a seek.
- R5: When cmd_byte[6:5] is nonzero, exactly one step is taken. If bit 6 is 1, bit 5 picks the direction (1 = outward, 0 = inward). If bit 6 is 0, the previous direction is reused.
- R6: For a single step, bit 4 set changes the track register by one in the step direction. Bit 4 clear leaves the track register unchanged.
- R7: If trk0_in is high when a move is to be outward, the track register becomes 0, no pulse is issued and positioning ends.
- R8: Each step pulse lasts STEP_PW clocks. Successive pulse starts are STEP_PW + rate_ms*TICKS_PER_MS + 1 clocks apart, where rate_ms is picked by cmd_byte[1:0] from RATE0_MS..RATE3_MS.
- R9: When cmd_byte[2] is 1, head_load rises at the end of positioning. id_req rises SETTLE_MS*TICKS_PER_MS clocks after that, and an ID whose track matches the track register ends the command with seek_err 0.
- R10: If no matching ID arrives within VERIFY_MS milliseconds of id_req rising, seek_err is set and the command ends.
- R11: At completion busy falls and irq rises together. irq and seek_err are cleared when the next command is accepted.
- R12: trk0_stat follows trk0_in with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_byte | input | 8 | Command byte |
| trk_wr | input | 1 | Track register write strobe |
| trk_wdata | input | TRK_W | Track register write value |
| dat_wr | input | 1 | Data (target) register write strobe |
| dat_wdata | input | TRK_W | Data register write value |
| trk0_in | input | 1 | Track-0 sensor, high at cylinder 0 |
| id_valid | input | 1 | ID detector presents an ID |
| id_track | input | TRK_W | Track field of the presented ID |
| track_out | output | TRK_W | Track register |
| data_out | output | TRK_W | Data register |
| step_out | output | 1 | Step pulse to the drive |
| step_dir | output | 1 | Direction, 1 = inward |
| head_load | output | 1 | Head engaged during verify |
| id_req | output | 1 | Request IDs from the detector |
| busy | output | 1 | Command in progress |
| seek_err | output | 1 | Verify failed |
| trk0_stat | output | 1 | Registered track-0 status |
| irq | output | 1 | Completion interrupt |

## Verification
The bench targets the following corner cases:
- A restore that starts already on track 0. Here the 0xFF preload and the sensor interact, and a design that tests the sensor before updating the track would emit a pulse.
- A step-out with update while the sensor is active. A wrong design leaves 0xFF in the track register.
- A plain step that must reuse the direction left by the previous command. A design that resets the direction would move the head the wrong way.
- Exact pulse spacing for several step rates, and the exact settle delay before the first ID request. An off-by-one in the prescaler or the state walk shows up here as a miscount.
- Verification against an ID detector that always reports the wrong track, which must end in seek_err rather than hang.
- A command and register writes issued while busy, which must not disturb the run.

// File: rtl/hps_pkg.sv
package hps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_DECIDE,
        ST_PULSE,
        ST_RATE,
        ST_SETTLE,
        ST_IDWAIT,
        ST_DONE
    } hps_state_e;

    typedef enum logic [2:0] {
        TOP_HOLD,
        TOP_LOAD,
        TOP_ALL1,
        TOP_INC,
        TOP_DEC,
        TOP_ZERO
    } trk_op_e;

    // Latched command fields (bit 3 and bit 7 are not needed after accept)
    typedef struct packed {
        logic       dir_given;  // bit 6
        logic       dir_outw;   // bit 5
        logic       flag4;      // bit 4: seek-vs-restore / track update
        logic       verify;     // bit 2
        logic [1:0] rate;       // bits 1:0
    } cmd_fields_t;

    function automatic int hps_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hps_ms_timer.sv
module hps_ms_timer #(
    parameter int TICKS_PER_MS = 8000,
    parameter int MS_W         = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MS_W-1:0] ms_len,
    output logic            expired
);
    localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICKS_PER_MS - 1);

    logic [PRE_W-1:0] pre;
    logic [MS_W-1:0]  remain;
    logic             running;
    logic             pre_wrap;

    assign pre_wrap = (pre == PRE_MAX);
    assign expired  = running && ((remain == '0) || (pre_wrap && remain == MS_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre     <= '0;
            remain  <= '0;
            running <= 1'b0;
        end else if (start) begin
            pre     <= '0;
            remain  <= ms_len;
            running <= 1'b1;
        end else if (running) begin
            if (expired) begin
                running <= 1'b0;
            end else if (pre_wrap) begin
                pre    <= '0;
                remain <= remain - MS_W'(1);
            end else begin
                pre <= pre + PRE_W'(1);
            end
        end
    end

endmodule

// File: rtl/hps_track_reg.sv
module hps_track_reg
    import hps_pkg::*;
#(
    parameter int TRK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  trk_op_e          op,
    input  logic [TRK_W-1:0] wr_val,
    input  logic [TRK_W-1:0] target,
    output logic [TRK_W-1:0] track,
    output logic             at_target,
    output logic             below_target
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            track <= '0;
        end else begin
            unique case (op)
                TOP_HOLD: track <= track;
                TOP_LOAD: track <= wr_val;
                TOP_ALL1: track <= '1;
                TOP_INC:  track <= track + TRK_W'(1);
                TOP_DEC:  track <= track - TRK_W'(1);
                TOP_ZERO: track <= '0;
                default:  track <= track;
            endcase
        end
    end

    assign at_target    = (track == target);
    assign below_target = (track < target);

endmodule

// File: rtl/head_pos_seq.sv
module head_pos_seq
    import hps_pkg::*;
#(
    parameter int TRK_W        = 8,
    parameter int TICKS_PER_MS = 8000,
    parameter int STEP_PW      = 16,
    parameter int RATE0_MS     = 6,
    parameter int RATE1_MS     = 12,
    parameter int RATE2_MS     = 20,
    parameter int RATE3_MS     = 30,
    parameter int SETTLE_MS    = 15,
    parameter int VERIFY_MS    = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    input  logic             trk_wr,
    input  logic [TRK_W-1:0] trk_wdata,
    input  logic             dat_wr,
    input  logic [TRK_W-1:0] dat_wdata,
    input  logic             trk0_in,
    input  logic             id_valid,
    input  logic [TRK_W-1:0] id_track,
    output logic [TRK_W-1:0] track_out,
    output logic [TRK_W-1:0] data_out,
    output logic             step_out,
    output logic             step_dir,
    output logic             head_load,
    output logic             id_req,
    output logic             busy,
    output logic             seek_err,
    output logic             trk0_stat,
    output logic             irq
);
    localparam int MS_MAX = hps_max(hps_max(hps_max(RATE0_MS, RATE1_MS), hps_max(RATE2_MS, RATE3_MS)),
                                    hps_max(SETTLE_MS, VERIFY_MS));
    localparam int MS_W   = $clog2(MS_MAX + 1);
    localparam int PW_W   = $clog2(STEP_PW + 1);
    localparam int RATE_MS [4] = '{RATE0_MS, RATE1_MS, RATE2_MS, RATE3_MS};

    hps_state_e       state, state_n;
    cmd_fields_t      cq;
    logic [TRK_W-1:0] dat_q;
    logic             dir_q;
    logic [PW_W-1:0]  pw_cnt;
    trk_op_e          trk_op;
    logic             at_target, below_target;
    logic             tmr_start, tmr_exp;
    logic [MS_W-1:0]  tmr_len;
    logic [MS_W-1:0]  rate_tab [4];

    logic accept, step_fam, is_restore, seek_hit, move_dir, out_stop, do_update, id_match;
    hps_state_e fin_state;
    logic unused_cmd_bit;

    assign unused_cmd_bit = cmd_byte[3];

    for (genvar g = 0; g < 4; g++) begin : g_rate
        assign rate_tab[g] = MS_W'(RATE_MS[g]);
    end

    // ---------------- decode ----------------
    assign accept     = (state == ST_IDLE) && cmd_valid && !cmd_byte[7];
    assign step_fam   = cq.dir_given | cq.dir_outw;
    assign is_restore = !step_fam && !cq.flag4;
    assign seek_hit   = !step_fam && at_target;
    assign move_dir   = step_fam ? dir_q : below_target;
    assign out_stop   = trk0_in && !move_dir;
    assign do_update  = step_fam ? cq.flag4 : 1'b1;
    assign id_match   = id_valid && (id_track == track_out);
    assign fin_state  = cq.verify ? ST_SETTLE : ST_DONE;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (accept) state_n = ST_PREP;
            ST_PREP:   state_n = ST_DECIDE;
            ST_DECIDE: begin
                if (seek_hit || out_stop) state_n = fin_state;
                else                      state_n = ST_PULSE;
            end
            ST_PULSE:  if (pw_cnt == PW_W'(STEP_PW - 1)) state_n = ST_RATE;
            ST_RATE:   if (tmr_exp) state_n = step_fam ? fin_state : ST_DECIDE;
            ST_SETTLE: if (tmr_exp) state_n = ST_IDWAIT;
            ST_IDWAIT: if (id_match || tmr_exp) state_n = ST_DONE;
            ST_DONE:   state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // ---------------- track register control ----------------
    always_comb begin
        trk_op = TOP_HOLD;
        unique case (state)
            ST_IDLE:   if (trk_wr) trk_op = TOP_LOAD;
            ST_PREP:   if (is_restore) trk_op = TOP_ALL1;
            ST_DECIDE: begin
                if (!seek_hit) begin
                    if (out_stop)       trk_op = TOP_ZERO;
                    else if (do_update) trk_op = move_dir ? TOP_INC : TOP_DEC;
                end
            end
            default:   trk_op = TOP_HOLD;
        endcase
    end

    hps_track_reg #(.TRK_W(TRK_W)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (trk_op),
        .wr_val       (trk_wdata),
        .target       (dat_q),
        .track        (track_out),
        .at_target    (at_target),
        .below_target (below_target)
    );

    // ---------------- delay timer ----------------
    always_comb begin
        tmr_start = 1'b0;
        tmr_len   = '0;
        if (state_n != state) begin
            unique case (state_n)
                ST_RATE:   begin tmr_start = 1'b1; tmr_len = rate_tab[cq.rate]; end
                ST_SETTLE: begin tmr_start = 1'b1; tmr_len = MS_W'(SETTLE_MS); end
                ST_IDWAIT: begin tmr_start = 1'b1; tmr_len = MS_W'(VERIFY_MS); end
                default:   tmr_start = 1'b0;
            endcase
        end
    end

    hps_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .ms_len  (tmr_len),
        .expired (tmr_exp)
    );

    // ---------------- datapath and status registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq        <= '0;
            dat_q     <= '0;
            dir_q     <= 1'b1;
            pw_cnt    <= '0;
            irq       <= 1'b0;
            seek_err  <= 1'b0;
            trk0_stat <= 1'b0;
        end else begin
            trk0_stat <= trk0_in;
            pw_cnt    <= (state == ST_PULSE) ? pw_cnt + PW_W'(1) : '0;
            if (accept) begin
                cq       <= '{dir_given: cmd_byte[6], dir_outw: cmd_byte[5], flag4: cmd_byte[4],
                              verify: cmd_byte[2], rate: cmd_byte[1:0]};
                irq      <= 1'b0;
                seek_err <= 1'b0;
            end
            if (state == ST_IDLE && dat_wr) dat_q <= dat_wdata;
            if (state == ST_PREP) begin
                if (is_restore)  dat_q <= '0;
                if (cq.dir_given) dir_q <= !cq.dir_outw;
            end
            if (state == ST_DECIDE && !step_fam && !seek_hit) dir_q <= below_target;
            if (state == ST_IDWAIT && !id_match && tmr_exp) seek_err <= 1'b1;
            if (state == ST_DONE) irq <= 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy      = (state != ST_IDLE);
        step_out  = (state == ST_PULSE);
        head_load = (state == ST_SETTLE) || (state == ST_IDWAIT);
        id_req    = (state == ST_IDWAIT);
        step_dir  = dir_q;
        data_out  = dat_q;
    end

endmodule

// File: rtl/hps_checker.sv
module hps_checker #(
    parameter int TRK_W   = 8,
    parameter int STEP_PW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_top,
    input logic             busy,
    input logic             irq,
    input logic             step_out,
    input logic [TRK_W-1:0] track_out,
    input logic             id_req,
    input logic             head_load,
    input logic             seek_err
);
    localparam int HC_W = $clog2(STEP_PW + 2);
    logic [HC_W-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_cnt <= '0;
        else        hi_cnt <= step_out ? hi_cnt + HC_W'(1) : '0;
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !cmd_top) |=> busy);

    assert_bit7_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_top) |=> !busy);

    assert_step_in_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_out |-> busy);

    assert_track_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && track_out != $past(track_out)) |->
        (track_out == $past(track_out) + TRK_W'(1) || track_out == $past(track_out) - TRK_W'(1) ||
         track_out == '0 || track_out == '1));

    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_out) |-> (hi_cnt == HC_W'(STEP_PW)));

    assert_idreq_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
        id_req |-> head_load);

    assert_err_from_search_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seek_err) |-> $past(id_req));

    assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);

endmodule

bind head_pos_seq hps_checker #(.TRK_W(TRK_W), .STEP_PW(STEP_PW)) u_hps_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_top   (cmd_byte[7]),
    .busy      (busy),
    .irq       (irq),
    .step_out  (step_out),
    .track_out (track_out),
    .id_req    (id_req),
    .head_load (head_load),
    .seek_err  (seek_err)
);

// File: tb/head_pos_seq_test.sv
`timescale 1ns/1ps
module head_pos_seq_test;
    localparam int TPM = 4;
    localparam int PW  = 3;
    localparam int SETTLE = 3;

    typedef struct packed {
        logic [7:0] phys, trk, dat, cmd, idoff, e_trk, e_steps, e_phys, e_dat;
        logic       e_dir, e_err;
    } vec_t;

    // phys trk dat cmd idoff | e_trk e_steps e_phys e_dat e_dir e_err
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'd0, 8'd0, 8'd5, 8'h10, 8'd0,  8'd5,  8'd5, 8'd5,  8'd5, 1'b1, 1'b0}, // R3 seek in
        '{8'd5, 8'd5, 8'd2, 8'h13, 8'd0,  8'd2,  8'd3, 8'd2,  8'd2, 1'b0, 1'b0}, // R3 seek out
        '{8'd7, 8'd7, 8'd7, 8'h11, 8'd0,  8'd7,  8'd0, 8'd7,  8'd7, 1'b0, 1'b0}, // R3 equal
        '{8'd3, 8'd3, 8'd9, 8'h00, 8'd0,  8'd0,  8'd3, 8'd0,  8'd0, 1'b0, 1'b0}, // R4 restore
        '{8'd4, 8'd4, 8'd0, 8'h50, 8'd0,  8'd5,  8'd1, 8'd5,  8'd0, 1'b1, 1'b0}, // R5 R6 in upd
        '{8'd4, 8'd4, 8'd0, 8'h60, 8'd0,  8'd4,  8'd1, 8'd3,  8'd0, 1'b0, 1'b0}, // R5 R6 out no upd
        '{8'd4, 8'd4, 8'd0, 8'h30, 8'd0,  8'd3,  8'd1, 8'd3,  8'd0, 1'b0, 1'b0}, // R5 keep out
        '{8'd9, 8'd9, 8'd0, 8'h40, 8'd0,  8'd9,  8'd1, 8'd10, 8'd0, 1'b1, 1'b0}, // R5 in no upd
        '{8'd9, 8'd9, 8'd0, 8'h30, 8'd0,  8'd10, 8'd1, 8'd10, 8'd0, 1'b1, 1'b0}, // R5 keep in
        '{8'd0, 8'd5, 8'd0, 8'h70, 8'd0,  8'd0,  8'd0, 8'd0,  8'd0, 1'b0, 1'b0}, // R7 out at trk0
        '{8'd2, 8'd2, 8'd4, 8'h14, 8'd0,  8'd4,  8'd2, 8'd4,  8'd4, 1'b1, 1'b0}, // R9 verify ok
        '{8'd4, 8'd4, 8'd6, 8'h14, 8'd1,  8'd6,  8'd2, 8'd6,  8'd6, 1'b1, 1'b1}, // R10 verify fail
        '{8'd6, 8'd6, 8'd3, 8'h04, 8'd0,  8'd0,  8'd6, 8'd0,  8'd0, 1'b0, 1'b0}, // R4 R9 restore+verify
        '{8'd0, 8'd0, 8'd0, 8'h00, 8'd0,  8'd0,  8'd0, 8'd0,  8'd0, 1'b0, 1'b0}  // R7 restore at 0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic trk_wr = 1'b0, dat_wr = 1'b0;
    logic [7:0] trk_wdata = '0, dat_wdata = '0;
    logic trk0_in;
    logic id_valid;
    logic [7:0] id_track;
    logic [7:0] track_out, data_out;
    logic step_out, step_dir, head_load, id_req, busy, seek_err, trk0_stat, irq;

    always #2 clk = ~clk;

    head_pos_seq #(
        .TRK_W(8), .TICKS_PER_MS(TPM), .STEP_PW(PW),
        .RATE0_MS(2), .RATE1_MS(3), .RATE2_MS(4), .RATE3_MS(6),
        .SETTLE_MS(SETTLE), .VERIFY_MS(20)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .trk_wr(trk_wr), .trk_wdata(trk_wdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .trk0_in(trk0_in), .id_valid(id_valid), .id_track(id_track),
        .track_out(track_out), .data_out(data_out), .step_out(step_out), .step_dir(step_dir),
        .head_load(head_load), .id_req(id_req), .busy(busy), .seek_err(seek_err),
        .trk0_stat(trk0_stat), .irq(irq)
    );

    // ---------------- drive model and monitors ----------------
    int   phys = 0;
    int   phys_val = 0;
    logic phys_ld = 1'b0;
    logic steps_clr = 1'b0;
    int   idoff = 0;
    int   steps = 0;
    int   cyc = 0;
    int   rise_last = 0, rise_prev = 0, idreq_rise = 0, wcnt = 0, last_width = 0;
    int   idc = 0;
    logic step_q = 1'b0, idreq_q = 1'b0;

    assign trk0_in = (phys == 0);

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        step_q  <= step_out;
        idreq_q <= id_req;
        wcnt    <= step_out ? wcnt + 1 : 0;
        if (!step_out && step_q) last_width <= wcnt;
        if (id_req && !idreq_q) idreq_rise <= cyc;
        if (phys_ld) phys <= phys_val;
        else if (step_out && !step_q) phys <= step_dir ? phys + 1 : ((phys == 0) ? 0 : phys - 1);
        if (steps_clr) steps <= 0;
        else if (step_out && !step_q) steps <= steps + 1;
        if (step_out && !step_q) begin
            rise_prev <= rise_last;
            rise_last <= cyc;
        end
    end

    always @(posedge clk) begin
        if (id_req) begin
            if (idc == 4) begin
                id_valid <= 1'b1;
                id_track <= 8'(phys + idoff);
                idc      <= 0;
            end else begin
                id_valid <= 1'b0;
                idc      <= idc + 1;
            end
        end else begin
            id_valid <= 1'b0;
            id_track <= '0;
            idc      <= 0;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic setup(input int trk, input int dat, input int ph, input int off);
        @(negedge clk);
        trk_wr = 1'b1; trk_wdata = 8'(trk);
        dat_wr = 1'b1; dat_wdata = 8'(dat);
        phys_val = ph; phys_ld = 1'b1; steps_clr = 1'b1; idoff = off;
        @(negedge clk);
        trk_wr = 1'b0; dat_wr = 1'b0; phys_ld = 1'b0; steps_clr = 1'b0;
    endtask

    task automatic issue(input logic [7:0] c);
        cmd_valid = 1'b1; cmd_byte = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic int rate_ms(input int i);
        case (i)
            0: return 2;
            1: return 3;
            2: return 4;
            default: return 6;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(track_out == 0, "R1", "track", track_out, 0);
        check(data_out == 0, "R1", "data", data_out, 0);
        check(!busy && !irq && !seek_err, "R1", "busy/irq/err", {busy, irq, seek_err}, 0);
        check(!step_out && step_dir, "R1", "step/dir", {step_out, step_dir}, 1);

        // R2 bit 7 commands are ignored
        issue(8'h80);
        @(negedge clk);
        check(!busy, "R2", "busy after bit7 cmd", busy, 0);
        check(!irq, "R2", "irq after bit7 cmd", irq, 0);

        // R12 track-0 status follows sensor
        setup(0, 0, 5, 0);
        repeat (2) @(negedge clk);
        check(trk0_stat == 1'b0, "R12", "trk0_stat off track 0", trk0_stat, 0);
        setup(0, 0, 0, 0);
        repeat (2) @(negedge clk);
        check(trk0_stat == 1'b1, "R12", "trk0_stat on track 0", trk0_stat, 1);

        // Table walk: R3..R10
        for (int i = 0; i < NV; i++) begin
            setup(VECS[i].trk, VECS[i].dat, VECS[i].phys, VECS[i].idoff);
            issue(VECS[i].cmd);
            check(busy, "R2", "busy after accept", busy, 1);
            wait_idle();
            check(track_out == VECS[i].e_trk, "R3", $sformatf("vec%0d track", i), track_out, VECS[i].e_trk);
            check(steps == int'(VECS[i].e_steps), "R5", $sformatf("vec%0d steps", i), steps, VECS[i].e_steps);
            check(phys == int'(VECS[i].e_phys), "R7", $sformatf("vec%0d head", i), phys, VECS[i].e_phys);
            check(data_out == VECS[i].e_dat, "R4", $sformatf("vec%0d data", i), data_out, VECS[i].e_dat);
            check(step_dir == VECS[i].e_dir, "R6", $sformatf("vec%0d dir", i), step_dir, VECS[i].e_dir);
            check(seek_err == VECS[i].e_err, "R10", $sformatf("vec%0d seek_err", i), seek_err, VECS[i].e_err);
            check(irq && !busy, "R11", $sformatf("vec%0d irq", i), irq, 1);
            if (i == 10) begin
                // R9: settle wait before the first ID request
                check(idreq_rise - rise_last == PW + 2*TPM + 1 + SETTLE*TPM, "R9", "settle spacing",
                      idreq_rise - rise_last, PW + 2*TPM + 1 + SETTLE*TPM);
            end
        end

        // R8 pulse width and spacing per rate code
        for (int r = 0; r < 4; r++) begin
            setup(0, 2, 0, 0);
            issue(8'h10 | 8'(r));
            wait_idle();
            check(rise_last - rise_prev == PW + rate_ms(r)*TPM + 1, "R8", $sformatf("spacing rate%0d", r),
                  rise_last - rise_prev, PW + rate_ms(r)*TPM + 1);
            check(last_width == PW, "R8", "pulse width", last_width, PW);
        end

        // R2 writes and commands while busy are ignored
        setup(0, 3, 0, 0);
        issue(8'h10);
        repeat (8) @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'h00;
        trk_wr = 1'b1; trk_wdata = 8'd50; dat_wr = 1'b1; dat_wdata = 8'd9;
        @(negedge clk);
        cmd_valid = 1'b0; trk_wr = 1'b0; dat_wr = 1'b0;
        wait_idle();
        check(track_out == 3, "R2", "track after busy writes", track_out, 3);
        check(data_out == 3, "R2", "data after busy writes", data_out, 3);
        check(steps == 3, "R2", "steps after busy cmd", steps, 3);

        // R11 irq cleared by the next accepted command
        check(irq, "R11", "irq set", irq, 1);
        issue(8'h11);
        check(!irq && busy, "R11", "irq cleared on accept", irq, 0);
        wait_idle();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule